// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address when the translation cache misses. It takes the address from a requester over a valid/ready handshake. It then reads two table entries, one after the other, through a memory read port that allows one outstanding request. The first entry comes from the top-level table that the base register points at. The second comes from the second-level table page that the first entry names. The block returns the frame number, the protection flags and the physical address, or it returns a page fault that names the level that failed.

The virtual address is split into three fields: a 10-bit top index in bits 31:22, a 10-bit second index in bits 21:12, and a 12-bit byte offset in bits 11:0. Every table entry is a 32-bit word with the following layout:

- Bits 31:12 hold a page number.
- Bits 11:4 are reserved.
- Bits 3:1 hold the protection flags.
- Bit 0 is the valid bit.

The walker copies the base register when a request is accepted, so the register may be reloaded while a walk runs without affecting that walk. Only one walk is in progress at any time.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_valid` is 0.
- R2: The first read of a walk targets the base value sampled when the request was accepted, plus 4 times vaddr[31:22]. A change on `ptbr` after acceptance has no effect on that read.
- R3: When the first entry has bit 0 set, the second read targets {entry[31:12], vaddr[21:12], 2'b00}.
- R4: When the second entry also has bit 0 set, the result has `rsp_fault`=0, `rsp_frame`=entry[31:12], `rsp_flags`=entry[3:1] and `rsp_paddr`={entry[31:12], vaddr[11:0]}.
- R5: When the first entry has bit 0 clear, the walk ends with `rsp_fault`=1 and `rsp_fault_level`=0, and no second read is issued.
- R6: When the second entry has bit 0 clear, the walk ends with `rsp_fault`=1 and `rsp_fault_level`=1.
- R7: A result stays on the outputs, unchanged, until `rsp_ready` is seen high. This covers `rsp_fault_vaddr`, which equals the virtual address of the walk.
- R8: `req_ready` is low from the moment a request is accepted until its result is acknowledged. A request that is presented during the acknowledge cycle is accepted on the following cycle.
- R9: `mem_rd_valid` stays high with a stable `mem_rd_addr` until `mem_rd_ready`. No new read is issued until the previous read has returned its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptbr | input | 32 | Byte address of the top-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry word |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address |
| rsp_frame | output | 20 | Physical frame number |
| rsp_flags | output | 3 | Protection flags of the final entry |
| rsp_fault | output | 1 | Walk ended in a page fault |
| rsp_fault_level | output | 1 | 0 means the top level failed, 1 means the second level failed |
| rsp_fault_vaddr | output | 32 | Virtual address of the walk |

## Verification
Two events can fall in the same cycle: the acknowledge of a finished result, and a new request from the requester. The bench provokes this by raising `rsp_ready` and `req_valid` together while a result is on the outputs. One cycle later it expects `req_ready` high, `rsp_valid` low and no memory read. One cycle after that it expects the first read of the new walk at the new address. A second overlap is a reload of `ptbr` in the cycle right after acceptance. It is judged by the address that the first read carries.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int FLAG_W = 3;
    localparam int PN_W   = VA_W - OFF_W;
    localparam int RSV_W  = OFF_W - FLAG_W - 1;
    localparam int WB_W   = 2;               // log2 of bytes per table word

    typedef struct packed {
        logic [IDX_W-1:0] top;
        logic [IDX_W-1:0] sec;
        logic [OFF_W-1:0] off;
    } vaddr_t;

    typedef struct packed {
        logic [PN_W-1:0]   pn;
        logic [RSV_W-1:0]  rsv;
        logic [FLAG_W-1:0] flags;
        logic              valid;
    } pte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_TOP,
        ST_WT_TOP,
        ST_RD_SEC,
        ST_WT_SEC,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    function automatic logic [VA_W-1:0] top_entry_addr(logic [VA_W-1:0] base, vaddr_t va);
        return base + {{(VA_W-IDX_W-WB_W){1'b0}}, va.top, {WB_W{1'b0}}};
    endfunction

    function automatic logic [VA_W-1:0] sec_entry_addr(logic [PN_W-1:0] pn, vaddr_t va);
        return {pn, va.sec, {WB_W{1'b0}}};
    endfunction
endpackage

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        mem_rd_ready,
    input  logic        mem_rsp_valid,
    input  logic        entry_ok,
    input  logic        rsp_ready,
    output walk_state_e state_q
);
    walk_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)     state_d = ST_RD_TOP;
            ST_RD_TOP: if (mem_rd_ready)  state_d = ST_WT_TOP;
            ST_WT_TOP: if (mem_rsp_valid) state_d = entry_ok ? ST_RD_SEC : ST_FAULT;
            ST_RD_SEC: if (mem_rd_ready)  state_d = ST_WT_SEC;
            ST_WT_SEC: if (mem_rsp_valid) state_d = entry_ok ? ST_DONE : ST_FAULT;
            ST_DONE,
            ST_FAULT:  if (rsp_ready)     state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // A fault is only ever entered on the cycle after returned read data
    assert_fault_after_data_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FAULT && $past(state_q) != ST_FAULT) |-> $past(mem_rsp_valid));
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  walk_state_e       state_i,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   base_i,
    input  logic [VA_W-1:0]   vaddr_i,
    input  logic              mem_rsp_valid,
    input  logic [VA_W-1:0]   mem_rsp_data,
    output logic              entry_ok,
    output logic [VA_W-1:0]   rd_addr,
    output vaddr_t            va_q,
    output pte_t              leaf_q,
    output logic              fault_lvl_q
);
    logic [VA_W-1:0] base_q;
    logic [PN_W-1:0] tbl_pn_q;
    pte_t            entry;
    logic            unused_rsv;

    assign entry      = pte_t'(mem_rsp_data);
    assign entry_ok   = entry.valid;
    assign unused_rsv = ^entry.rsv;
    assign rd_addr    = (state_i == ST_RD_TOP) ? top_entry_addr(base_q, va_q)
                                               : sec_entry_addr(tbl_pn_q, va_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q      <= '0;
            va_q        <= '0;
            tbl_pn_q    <= '0;
            leaf_q      <= '0;
            fault_lvl_q <= 1'b0;
        end else begin
            if (state_i == ST_IDLE && req_valid) begin
                base_q <= base_i;
                va_q   <= vaddr_t'(vaddr_i);
            end
            if (state_i == ST_WT_TOP && mem_rsp_valid) begin
                tbl_pn_q    <= entry.pn;
                fault_lvl_q <= 1'b0;
            end
            if (state_i == ST_WT_SEC && mem_rsp_valid) begin
                leaf_q      <= entry;
                fault_lvl_q <= 1'b1;
            end
        end
    end

    // Captured virtual address must not move while a walk is under way
    assert_va_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (state_i != ST_IDLE) |=> (state_i == ST_IDLE) || $stable(va_q));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [VA_W-1:0]   ptbr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [VA_W-1:0]   mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [VA_W-1:0]   mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [VA_W-1:0]   rsp_paddr,
    output logic [PN_W-1:0]   rsp_frame,
    output logic [FLAG_W-1:0] rsp_flags,
    output logic              rsp_fault,
    output logic              rsp_fault_level,
    output logic [VA_W-1:0]   rsp_fault_vaddr
);
    walk_state_e state_q;
    logic        entry_ok;
    vaddr_t      va_q;
    pte_t        leaf_q;
    logic        fault_lvl_q;

    ptw_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .entry_ok      (entry_ok),
        .rsp_ready     (rsp_ready),
        .state_q       (state_q)
    );

    ptw_datapath u_dp (
        .clk           (clk),
        .rst           (rst),
        .state_i       (state_q),
        .req_valid     (req_valid),
        .base_i        (ptbr),
        .vaddr_i       (req_vaddr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .entry_ok      (entry_ok),
        .rd_addr       (mem_rd_addr),
        .va_q          (va_q),
        .leaf_q        (leaf_q),
        .fault_lvl_q   (fault_lvl_q)
    );

    assign req_ready       = (state_q == ST_IDLE);
    assign mem_rd_valid    = (state_q == ST_RD_TOP) || (state_q == ST_RD_SEC);
    assign rsp_valid       = (state_q == ST_DONE) || (state_q == ST_FAULT);
    assign rsp_fault       = (state_q == ST_FAULT);
    assign rsp_fault_level = fault_lvl_q;
    assign rsp_fault_vaddr = va_q;
    assign rsp_frame       = leaf_q.pn;
    assign rsp_flags       = leaf_q.flags;
    assign rsp_paddr       = {leaf_q.pn, va_q.off};

    assert_single_walk_R8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!rsp_valid && !mem_rd_valid));

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    assert_one_read_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && mem_rd_ready) |=> !mem_rd_valid);

    assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault) &&
            $stable(rsp_paddr) && $stable(rsp_fault_vaddr) && $stable(rsp_fault_level)));
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ptbr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic [19:0] rsp_frame;
    logic [2:0]  rsp_flags;
    logic        rsp_fault;
    logic        rsp_fault_level;
    logic [31:0] rsp_fault_vaddr;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    pt_walker uut (
        .clk(clk), .rst(rst), .ptbr(ptbr),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_frame(rsp_frame), .rsp_flags(rsp_flags), .rsp_fault(rsp_fault),
        .rsp_fault_level(rsp_fault_level), .rsp_fault_vaddr(rsp_fault_vaddr)
    );

    // Memory model: sparse word store, fixed latency, one read at a time
    logic [31:0] mem [logic [31:0]];
    logic        busy = 1'b0;
    logic        stall = 1'b0;
    int          lat = 0;
    int          cnt = 0;
    logic [31:0] addr_q = '0;
    logic [31:0] rd_log [64];
    int          rd_n = 0;

    assign mem_rd_ready = !busy && !stall;

    function automatic logic [31:0] lookup(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rst) begin
            busy <= 1'b0;
        end else if (busy) begin
            if (cnt == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= lookup(addr_q);
                busy          <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end else if (mem_rd_valid && mem_rd_ready) begin
            busy            <= 1'b1;
            addr_q          <= mem_rd_addr;
            cnt             <= lat;
            rd_log[rd_n%64] <= mem_rd_addr;
            rd_n            <= rd_n + 1;
        end
    end

    function automatic logic [31:0] pte(logic [19:0] pn, logic [2:0] fl, logic v);
        return {pn, 8'hA5, fl, v};
    endfunction

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    int rd_base = 0;

    task automatic issue(logic [31:0] va, logic [31:0] base);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        ptbr      = base;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        ptbr      = base ^ 32'h5555_5000;   // reload after acceptance
    endtask

    // Waits for a result, checks it, optionally holds it, optionally acknowledges
    task automatic collect(logic [31:0] va, logic [31:0] base, logic [19:0] tpn,
                           logic exp_fault, logic exp_lvl, logic [19:0] frame,
                           logic [2:0] fl, int hold, logic do_ack);
        int guard = 0;
        logic busy_ready = 1'b0;
        int reads;
        logic [31:0] a1 = base + {20'h0, va[31:22], 2'b00};
        logic [31:0] a2 = {tpn, va[21:12], 2'b00};
        while (!rsp_valid && guard < 500) begin
            if (req_ready) busy_ready = 1'b1;
            @(negedge clk);
            guard++;
        end
        chk("R8 req_ready low during walk", {31'h0, busy_ready}, 32'h0);
        chk("R7 result presented", {31'h0, rsp_valid}, 32'h1);
        reads = rd_n - rd_base;
        chk("R2 top entry read address", rd_log[rd_base%64], a1);
        if (exp_fault && !exp_lvl) begin
            chk("R5 single read on top fault", reads, 1);
        end else begin
            chk("R9 two reads", reads, 2);
            chk("R3 second entry read address", rd_log[(rd_base+1)%64], a2);
        end
        chk("R5 R6 fault flag", {31'h0, rsp_fault}, {31'h0, exp_fault});
        chk("R7 fault vaddr", rsp_fault_vaddr, va);
        if (exp_fault) begin
            chk("R5 R6 fault level", {31'h0, rsp_fault_level}, {31'h0, exp_lvl});
        end else begin
            chk("R4 frame", {12'h0, rsp_frame}, {12'h0, frame});
            chk("R4 flags", {29'h0, rsp_flags}, {29'h0, fl});
            chk("R4 paddr", rsp_paddr, {frame, va[11:0]});
        end
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk("R7 held valid", {31'h0, rsp_valid}, 32'h1);
            chk("R7 held vaddr", rsp_fault_vaddr, va);
            chk("R7 held fault", {31'h0, rsp_fault}, {31'h0, exp_fault});
            if (!exp_fault) chk("R7 held paddr", rsp_paddr, {frame, va[11:0]});
        end
        if (do_ack) begin
            rsp_ready = 1'b1;
            @(negedge clk);
            rsp_ready = 1'b0;
            chk("R8 idle after ack", {30'h0, req_ready, rsp_valid}, 32'h2);
        end
    endtask

    task automatic map(logic [31:0] va, logic [31:0] base, logic [19:0] tpn, logic v1,
                       logic [19:0] frame, logic [2:0] fl, logic v2);
        mem[base + {20'h0, va[31:22], 2'b00}] = pte(tpn, 3'b111, v1);
        mem[{tpn, va[21:12], 2'b00}]           = pte(frame, fl, v2);
    endtask

    task automatic walk(logic [31:0] va, logic [31:0] base, logic [19:0] tpn, logic v1,
                        logic [19:0] frame, logic [2:0] fl, logic v2, int hold);
        map(va, base, tpn, v1, frame, fl, v2);
        rd_base = rd_n;
        issue(va, base);
        collect(va, base, tpn, !(v1 && v2), v1, frame, fl, hold, 1'b1);
    endtask

    task automatic test_reset();
        chk("R1 req_ready", {31'h0, req_ready}, 32'h1);
        chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        chk("R1 mem_rd_valid", {31'h0, mem_rd_valid}, 32'h0);
    endtask

    task automatic test_stall();
        logic [31:0] va = 32'h1234_5678;
        logic [31:0] base = 32'h0003_0000;
        map(va, base, 20'h00777, 1'b1, 20'h0BEEF, 3'b010, 1'b1);
        stall = 1'b1;
        rd_base = rd_n;
        issue(va, base);
        for (int k = 0; k < 3; k++) begin
            chk("R9 read held while stalled", {31'h0, mem_rd_valid}, 32'h1);
            chk("R9 address stable", mem_rd_addr, base + {20'h0, va[31:22], 2'b00});
            @(negedge clk);
        end
        stall = 1'b0;
        collect(va, base, 20'h00777, 1'b0, 1'b0, 20'h0BEEF, 3'b010, 0, 1'b1);
    endtask

    task automatic test_overlap();
        logic [31:0] va1 = 32'h4050_6070;
        logic [31:0] va2 = 32'h8090_A0B0;
        logic [31:0] base = 32'h0004_0000;
        map(va1, base, 20'h00301, 1'b1, 20'h11111, 3'b001, 1'b1);
        map(va2, base, 20'h00302, 1'b1, 20'h22222, 3'b100, 1'b1);
        rd_base = rd_n;
        issue(va1, base);
        collect(va1, base, 20'h00301, 1'b0, 1'b0, 20'h11111, 3'b001, 0, 1'b0);
        rsp_ready = 1'b1;
        req_valid = 1'b1;
        req_vaddr = va2;
        ptbr      = base;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R8 not taken during ack", {29'h0, req_ready, rsp_valid, mem_rd_valid}, 32'h4);
        rd_base = rd_n;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 pending request accepted next cycle", {31'h0, mem_rd_valid}, 32'h1);
        chk("R8 R2 address of pending request", mem_rd_addr, base + {20'h0, va2[31:22], 2'b00});
        collect(va2, base, 20'h00302, 1'b0, 1'b0, 20'h22222, 3'b100, 0, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();                                                            // R1
        lat = 0;
        walk(32'h00C0_3ABC, 32'h0010_0000, 20'h00200, 1, 20'hABCDE, 3'b101, 1, 0); // R2 R3 R4
        lat = 3;
        walk(32'hFEDC_B123, 32'h0020_0000, 20'h00456, 1, 20'h13579, 3'b011, 1, 3); // R7
        walk(32'h3333_3444, 32'h0021_0000, 20'h00999, 0, 20'h0AAAA, 3'b111, 1, 2); // R5
        lat = 1;
        walk(32'h7654_3210, 32'h0022_0000, 20'h00888, 1, 20'h0CCCC, 3'b110, 0, 1); // R6
        walk(32'hFFFF_FFFF, 32'h0000_F000, 20'hFFFFF, 1, 20'hFFFFE, 3'b111, 1, 0); // R2 R4 top indices
        walk(32'h0000_0000, 32'h0000_0000, 20'h00001, 1, 20'h00002, 3'b000, 1, 0); // R3 R4 zero indices
        lat = 0;
        test_stall();                                                            // R9
        test_overlap();                                                          // R8
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule